// File: doc/BRIEF.md
# Sub-Word Memory Access Unit

This unit connects a load/store pipeline to a small internal store organised as 8-byte words. Each request carries a byte address, a two-bit size code, a load/store flag and store data. The low address bits select a byte position inside a word, and the remaining bits select the word. Loads return the selected bytes right-justified and zero-filled. A store of fewer than eight bytes reads the word, replaces only the selected bytes and writes the result back. A store of the full eight bytes replaces the word in a single cycle.

Bytes inside a word are numbered big-endian. Byte position 0 is the most significant byte. A request whose byte position is not a multiple of its size is refused. The refusal is reported as a one-cycle error flag, and the stored data is left untouched. The unit does not split such a request into smaller accesses.

A request is accepted on any rising clock edge where `req_valid` is high and `busy` is low. While `busy` is high, requests are not accepted.

Top module: `lane_access_unit`

## Requirements
- R1: The word index is the address shifted right by 3, and the byte position is the address ANDed with 7. A store to one word leaves every other word unchanged.
- R2: `req_size` encodes the access size as follows: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes.
- R3: A request is misaligned when its byte position is not a multiple of its size. A misaligned request that is accepted raises `misalign_err` for exactly the one cycle after the accepting edge. It produces no `rsp_valid` and does not set `busy`.
- R4: A misaligned store does not change the stored data.
- R5: The selected bytes occupy data bits starting at ((8 - size_in_bytes) - byte_position) * 8. Byte position 0 therefore holds bits 63:56.
- R6: An aligned load drives `rsp_valid` high for the cycle after the accepting edge. In that cycle `rsp_rdata` holds the selected bytes shifted down to bit 0, with all higher bits zero.
- R7: A store of 1, 2 or 4 bytes changes only the selected bytes of the word. All other bytes of the word keep their previous value.
- R8: A store of 1, 2 or 4 bytes holds `busy` high for exactly one cycle after the accepting edge. A request presented while `busy` is high is ignored.
- R9: An aligned 8-byte store writes the whole word at the accepting edge and never raises `busy`.
- R10: After reset, a word that has never been written reads as zero.
- R11: On a store, bits of `req_wdata` above the access size are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented |
| req_store | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code (0 = 1 byte, 1 = 2, 2 = 4, 3 = 8) |
| req_wdata | input | 64 | Store data, right-justified |
| busy | output | 1 | A read-modify-write is in its write cycle |
| rsp_valid | output | 1 | Load data is valid |
| rsp_rdata | output | 64 | Load data, right-justified and zero-filled |
| misalign_err | output | 1 | The accepted request was misaligned |

## Verification
The following results appear in the cycle after the accepting edge:
- load data and `rsp_valid`;
- the misalignment flag;
- the `busy` pulse of a read-modify-write.

A sub-word store lands in the word at the second edge after acceptance. Each scenario task drives its inputs on a falling edge and samples the outputs on the next falling edge, which falls inside the response cycle. For a read-modify-write, the task waits one further falling edge before checking that `busy` has dropped. The stored contents are then read back through ordinary loads, never by looking inside the design.

// File: rtl/lane_access_pkg.sv
package lane_access_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_QUAD  = 2'd2,
      SZ_OCTET = 2'd3
   } acc_size_e;

   typedef enum logic {
      CTL_IDLE  = 1'b0,
      CTL_MERGE = 1'b1
   } ctl_state_e;

   // Byte count of a size code, held in 4 bits.
   function automatic logic [3:0] size_to_bytes(input acc_size_e sz);
      return 4'd1 << sz;
   endfunction

endpackage

// File: rtl/lane_decode.sv
module lane_decode
   import lane_access_pkg::*;
#(
   parameter int unsigned ADDR_W     = 7,
   parameter int unsigned WORD_BYTES = 8,
   localparam int unsigned DW    = WORD_BYTES * 8,
   localparam int unsigned OFF_W = $clog2(WORD_BYTES),
   localparam int unsigned IDX_W = ADDR_W - OFF_W,
   localparam int unsigned SH_W  = $clog2(DW)
) (
   input  logic [ADDR_W-1:0] addr,
   input  acc_size_e         size,
   output logic [IDX_W-1:0]  word_idx,
   output logic [SH_W-1:0]   lane_shift,
   output logic [DW-1:0]     width_mask,
   output logic [DW-1:0]     lane_mask,
   output logic              misaligned,
   output logic              full_word
);

   logic [3:0]       bytes_n;
   logic [3:0]       off_ext;
   logic [OFF_W-1:0] shift_bytes;
   logic             oversize;

   assign bytes_n  = size_to_bytes(size);
   assign off_ext  = 4'(addr[OFF_W-1:0]);
   assign word_idx = addr[ADDR_W-1:OFF_W];

   assign oversize   = bytes_n > 4'(WORD_BYTES);
   assign misaligned = oversize || ((off_ext & (bytes_n - 4'd1)) != 4'd0);
   assign full_word  = (bytes_n == 4'(WORD_BYTES));

   // Big-endian lanes: byte position 0 is the top byte of the word.
   assign shift_bytes = OFF_W'(4'(WORD_BYTES) - bytes_n - off_ext);
   assign lane_shift  = {shift_bytes, 3'b000};

   for (genvar b = 0; b < WORD_BYTES; b++) begin : g_wmask
      assign width_mask[8*b +: 8] = (4'(b) < bytes_n) ? 8'hFF : 8'h00;
   end

   assign lane_mask = width_mask << lane_shift;

endmodule

// File: rtl/word_store.sv
module word_store #(
   parameter int unsigned DW    = 64,
   parameter int unsigned IDX_W = 4,
   localparam int unsigned DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [DW-1:0]    wr_data,
   output logic [DW-1:0]    rd_data
);

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (wr_en) begin
         cells[wr_idx] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= cells[rd_idx];
   end

endmodule

// File: rtl/lane_access_unit.sv
module lane_access_unit
   import lane_access_pkg::*;
#(
   parameter int unsigned ADDR_W     = 7,
   parameter int unsigned WORD_BYTES = 8,
   localparam int unsigned DW = WORD_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_store,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [DW-1:0]     req_wdata,
   output logic              busy,
   output logic              rsp_valid,
   output logic [DW-1:0]     rsp_rdata,
   output logic              misalign_err
);

   localparam int unsigned OFF_W = $clog2(WORD_BYTES);
   localparam int unsigned IDX_W = ADDR_W - OFF_W;
   localparam int unsigned SH_W  = $clog2(DW);

   if (WORD_BYTES != 2 && WORD_BYTES != 4 && WORD_BYTES != 8) begin : g_bad_word
      $error("WORD_BYTES must be 2, 4 or 8");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W must leave at least one word index bit");
   end

   ctl_state_e       state_q;
   logic [IDX_W-1:0] idx, idx_q;
   logic [SH_W-1:0]  shift, shift_q;
   logic [DW-1:0]    wmask, lmask, wmask_q, lmask_q, wdata_q;
   logic             mis, full;
   logic             accept, go_load, go_full, go_rmw;
   logic             rsp_q, err_q;
   logic             mem_wr;
   logic [IDX_W-1:0] mem_wr_idx;
   logic [DW-1:0]    mem_wr_data, mem_rd_data, merged;

   lane_decode #(
      .ADDR_W    (ADDR_W),
      .WORD_BYTES(WORD_BYTES)
   ) u_dec (
      .addr      (req_addr),
      .size      (acc_size_e'(req_size)),
      .word_idx  (idx),
      .lane_shift(shift),
      .width_mask(wmask),
      .lane_mask (lmask),
      .misaligned(mis),
      .full_word (full)
   );

   assign accept  = req_valid && (state_q == CTL_IDLE);
   assign go_load = accept && !req_store && !mis;
   assign go_full = accept &&  req_store && !mis &&  full;
   assign go_rmw  = accept &&  req_store && !mis && !full;

   assign merged = (mem_rd_data & ~lmask_q) | (wdata_q << shift_q);

   always_comb begin
      mem_wr      = go_full || (state_q == CTL_MERGE);
      mem_wr_idx  = (state_q == CTL_MERGE) ? idx_q  : idx;
      mem_wr_data = (state_q == CTL_MERGE) ? merged : req_wdata;
   end

   word_store #(
      .DW   (DW),
      .IDX_W(IDX_W)
   ) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (go_load || go_rmw),
      .rd_idx (idx),
      .wr_en  (mem_wr),
      .wr_idx (mem_wr_idx),
      .wr_data(mem_wr_data),
      .rd_data(mem_rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= CTL_IDLE;
         rsp_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         state_q <= go_rmw ? CTL_MERGE : CTL_IDLE;
         rsp_q   <= go_load;
         err_q   <= accept && mis;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         shift_q <= '0;
         wmask_q <= '0;
         lmask_q <= '0;
         wdata_q <= '0;
      end else if (go_load || go_rmw) begin
         idx_q   <= idx;
         shift_q <= shift;
         wmask_q <= wmask;
         lmask_q <= lmask;
         wdata_q <= req_wdata & wmask;
      end
   end

   assign busy         = (state_q == CTL_MERGE);
   assign rsp_valid    = rsp_q;
   assign misalign_err = err_q;
   assign rsp_rdata    = (mem_rd_data >> shift_q) & wmask_q;

endmodule

// File: rtl/lane_access_chk.sv
module lane_access_chk #(
   parameter int unsigned ADDR_W     = 7,
   parameter int unsigned WORD_BYTES = 8,
   localparam int unsigned DW = WORD_BYTES * 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_store,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_size,
   input logic              busy,
   input logic              rsp_valid,
   input logic [DW-1:0]     rsp_rdata,
   input logic              misalign_err
);

   logic [3:0] nbytes;
   logic       acc, legal, sub_word;

   assign nbytes   = 4'd1 << req_size;
   assign acc      = req_valid && !busy;
   assign legal    = (nbytes <= 4'(WORD_BYTES)) &&
                     ((req_addr & ADDR_W'(nbytes - 4'd1)) == '0);
   assign sub_word = nbytes < 4'(WORD_BYTES);

   assert_load_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !req_store && legal |=> rsp_valid && !misalign_err);

   assert_misalign_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !legal |=> misalign_err && !rsp_valid && !busy);

   assert_rmw_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_store && legal && sub_word |=> busy && !rsp_valid);

   assert_busy_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy && !rsp_valid && !misalign_err);

   assert_full_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
      acc && req_store && legal && !sub_word |=> !busy && !rsp_valid);

   assert_zero_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && $past(req_size) == 2'd0 |-> (rsp_rdata >> 8) == '0);

   assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_valid && misalign_err));

endmodule

bind lane_access_unit lane_access_chk #(
   .ADDR_W    (ADDR_W),
   .WORD_BYTES(WORD_BYTES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_store   (req_store),
   .req_addr    (req_addr),
   .req_size    (req_size),
   .busy        (busy),
   .rsp_valid   (rsp_valid),
   .rsp_rdata   (rsp_rdata),
   .misalign_err(misalign_err)
);

// File: tb/sim_lane_access_unit.sv
module sim_lane_access_unit;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_store = 1'b0;
   logic [6:0]  req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [63:0] req_wdata = '0;
   logic        busy, rsp_valid, misalign_err;
   logic [63:0] rsp_rdata;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lane_access_unit u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .misalign_err(misalign_err)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Present one request for one edge; returns at the falling edge after it.
   task automatic issue(input bit st, input logic [6:0] a, input logic [1:0] sz,
                        input logic [63:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_store = st; req_addr = a; req_size = sz; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic load_chk(input logic [6:0] a, input logic [1:0] sz,
                           input logic [63:0] exp, input string tag);
      issue(1'b0, a, sz, '0);
      chk(rsp_valid === 1'b1, {tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
      chk(misalign_err === 1'b0, {tag, " no err"}, 64'(misalign_err), 64'd0);
      chk(rsp_rdata === exp, {tag, " data"}, rsp_rdata, exp);
   endtask

   // Sub-word store: busy for one cycle, then free.
   task automatic rmw_store(input logic [6:0] a, input logic [1:0] sz,
                            input logic [63:0] d, input string tag);
      issue(1'b1, a, sz, d);
      chk(busy === 1'b1, {tag, " busy raised"}, 64'(busy), 64'd1);
      @(negedge clk);
      chk(busy === 1'b0, {tag, " busy dropped"}, 64'(busy), 64'd0);
   endtask

   task automatic t_reset();
      chk(busy === 1'b0 && rsp_valid === 1'b0 && misalign_err === 1'b0,
          "R10 reset outputs", {61'd0, busy, rsp_valid, misalign_err}, 64'd0);
      load_chk(7'h18, 2'd3, 64'd0, "R10 unwritten word");
   endtask

   task automatic t_full_store();
      issue(1'b1, 7'h00, 2'd3, 64'h0011223344556677);
      chk(busy === 1'b0 && rsp_valid === 1'b0, "R9 full store no busy",
          {62'd0, busy, rsp_valid}, 64'd0);
      load_chk(7'h00, 2'd3, 64'h0011223344556677, "R9 full readback");
      issue(1'b1, 7'h08, 2'd3, 64'h8877665544332211);
   endtask

   task automatic t_lanes();
      load_chk(7'h08, 2'd0, 64'h88, "R5 byte pos0 is top byte");
      load_chk(7'h0F, 2'd0, 64'h11, "R5 byte pos7");
      load_chk(7'h0A, 2'd1, 64'h6655, "R2 R6 half at pos2");
      load_chk(7'h0C, 2'd2, 64'h44332211, "R2 R6 quad at pos4");
   endtask

   task automatic t_merge();
      rmw_store(7'h09, 2'd0, 64'hFFFFFFFFFFFFFFAB, "R8 byte store");
      load_chk(7'h08, 2'd3, 64'h88AB665544332211, "R7 R11 byte merge");
      load_chk(7'h09, 2'd0, 64'hAB, "R7 byte reload");
      rmw_store(7'h0C, 2'd2, 64'h12345678CAFEF00D, "R8 quad store");
      load_chk(7'h08, 2'd3, 64'h88AB6655CAFEF00D, "R7 R11 quad merge");
   endtask

   task automatic t_misalign();
      issue(1'b0, 7'h09, 2'd1, '0);
      chk(misalign_err === 1'b1 && rsp_valid === 1'b0, "R3 misaligned load",
          {62'd0, misalign_err, rsp_valid}, 64'h2);
      @(negedge clk);
      chk(misalign_err === 1'b0, "R3 error lasts one cycle", 64'(misalign_err), 64'd0);
      issue(1'b0, 7'h04, 2'd3, '0);
      chk(misalign_err === 1'b1, "R3 misaligned full load", 64'(misalign_err), 64'd1);
      issue(1'b1, 7'h06, 2'd2, 64'hFFFFFFFFFFFFFFFF);
      chk(misalign_err === 1'b1 && busy === 1'b0, "R3 misaligned store",
          {62'd0, misalign_err, busy}, 64'h2);
      load_chk(7'h00, 2'd3, 64'h0011223344556677, "R4 word unchanged");
   endtask

   task automatic t_busy_ignore();
      issue(1'b1, 7'h10, 2'd1, 64'h000000000000BEEF);
      chk(busy === 1'b1, "R8 half store busy", 64'(busy), 64'd1);
      req_valid = 1'b1; req_store = 1'b1; req_addr = 7'h18;
      req_size = 2'd3; req_wdata = 64'h1234;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy === 1'b0, "R8 busy one cycle", 64'(busy), 64'd0);
      load_chk(7'h18, 2'd3, 64'd0, "R8 request during busy ignored");
      load_chk(7'h10, 2'd3, 64'hBEEF000000000000, "R5 R7 half at pos0");
   endtask

   task automatic t_index();
      issue(1'b1, 7'h78, 2'd3, 64'hA5A5A5A5A5A5A5A5);
      load_chk(7'h78, 2'd3, 64'hA5A5A5A5A5A5A5A5, "R1 last word");
      load_chk(7'h00, 2'd3, 64'h0011223344556677, "R1 other word intact");
      load_chk(7'h7F, 2'd0, 64'hA5, "R1 offset from low bits");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_store();
      t_lanes();
      t_merge();
      t_misalign();
      t_busy_ignore();
      t_index();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule